// File: doc/BRIEF.md
# Sprite Table Copy Engine with Bus Arbitration

This block copies a 160-byte page of memory into the sprite attribute table and, while the copy runs, decides what every CPU access sees. The CPU starts a copy by writing a page number P to the copy-source register at `$FF46`. From then on the engine reads `P*256 + k` and writes that byte to sprite-table index k, one byte per clock. The whole copy takes 160 clocks.

The external memory sits on one of two buses. In shared mode (`split_mode` low), cartridge space and work RAM both go over the cartridge port. In split mode, work RAM `$C000-$DFFF` has its own port. The engine owns whichever port holds its source page. A CPU read that targets that port is answered with the byte being copied in that same cycle. A CPU write to that port is dropped. The other port, and the internal high RAM at `$FF80-$FFFE`, stay fully usable.

All read paths are combinational. An access is presented for one clock and its read data is valid in the same cycle. There is no back-pressure: the CPU port accepts an access every cycle, and the engine never stalls the CPU. It only substitutes or drops data.

Top module: `sprite_dma_hub`

## Requirements
- R1: After reset `dma_busy` is 0 and reading `$FF46` returns `$00`. A CPU write of value P to `$FF46` while idle stores P, which later reads of `$FF46` return. `dma_busy` is then high for exactly the 160 cycles that follow the write.
- R2: In busy cycle k (k = 0 for the first busy cycle, up to 159), the block reads source address `{P', k}` and writes the read byte to the sprite table with `oam_we`=1, `oam_addr`=k and `oam_wdata`= that byte. P' is the effective source page defined in R10.
- R3: In shared mode during a copy whose source is external, a CPU read from cartridge space (`$0000-$7FFF`, `$A000-$BFFF`) or work RAM (`$C000-$DFFF`) returns the byte being copied in that cycle.
- R4: In split mode with the source in work RAM, CPU work-RAM reads return the byte being copied. CPU cartridge reads and writes reach the cartridge port unchanged.
- R5: In split mode with the source in cartridge space, CPU cartridge reads return the byte being copied. CPU work-RAM reads and writes reach the work-RAM port unchanged.
- R6: During a copy, a CPU write whose target is the port the engine reads from raises no write strobe. A CPU write to the other port is passed on with its address and data.
- R7: During a copy, CPU reads of `$FE00-$FE9F` return `$FF` and CPU writes there do not reach the sprite table. When idle, CPU reads and writes map to sprite-table index `addr[7:0]`.
- R8: High RAM `$FF80-$FFFE` (127 bytes) can be read and written at any time, including during a copy.
- R9: A write to `$FF46` during a copy is ignored. The copy neither restarts nor lengthens, and `$FF46` keeps the page that started the copy.
- R10: A source page of `$E0` or above reads work RAM with address bit 13 cleared (page minus `$20`). A source page in `$80-$9F` copies `$FF` into every entry and leaves both ports to the CPU.
- R11: CPU reads from `$8000-$9FFF`, `$E000-$FDFF`, `$FEA0-$FF7F` (except `$FF46`) and `$FFFF` return `$FF`.
- R12: When idle, a CPU access to cartridge space goes to the cartridge port. A CPU access to work RAM goes to the work-RAM port in split mode and to the cartridge port in shared mode. In both cases the address is passed unchanged and read data is returned as-is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| split_mode | input | 1 | 1: work RAM on its own port; 0: single shared port. Must be stable during a copy |
| cpu_en | input | 1 | CPU access present this cycle |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, same cycle |
| dma_busy | output | 1 | Copy in progress |
| cart_addr | output | 16 | Cartridge (or shared) port address |
| cart_rd | output | 1 | Cartridge port read strobe |
| cart_wr | output | 1 | Cartridge port write strobe |
| cart_wdata | output | 8 | Cartridge port write data |
| cart_rdata | input | 8 | Cartridge port read data, same cycle |
| wram_addr | output | 16 | Work-RAM port address |
| wram_rd | output | 1 | Work-RAM port read strobe |
| wram_wr | output | 1 | Work-RAM port write strobe |
| wram_wdata | output | 8 | Work-RAM port write data |
| wram_rdata | input | 8 | Work-RAM port read data, same cycle |
| oam_addr | output | 8 | Sprite table index |
| oam_we | output | 1 | Sprite table write strobe |
| oam_wdata | output | 8 | Sprite table write data |
| oam_rdata | input | 8 | Sprite table read data, same cycle |

## Verification
The hardest case is a CPU read that lands on the engine's own port in a given cycle. The returned byte must match the copy index of exactly that cycle, and a one-cycle skew would still look plausible. The bench therefore issues a random CPU access in every one of the 160 busy cycles of each copy. It varies the source page across cartridge, work-RAM, mirrored and empty pages, and covers both bus modes. The source memories are address functions, so the expected moving byte is known for every index. One directed copy also pokes `$FF46` mid-transfer to check that no restart happens.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

  typedef enum logic [2:0] {
    RG_CART, RG_WRAM, RG_OAM, RG_HRAM, RG_SRCREG, RG_NONE
  } region_e;

  typedef enum logic [1:0] {
    PT_NONE, PT_CART, PT_WRAM
  } port_e;

  function automatic region_e region_of(input logic [15:0] a);
    region_e r;
    if (!a[15] || a[15:13] == 3'b101)          r = RG_CART;
    else if (a[15:13] == 3'b110)               r = RG_WRAM;
    else if (a >= 16'hFE00 && a <= 16'hFE9F)   r = RG_OAM;
    else if (a == 16'hFF46)                    r = RG_SRCREG;
    else if (a >= 16'hFF80 && a != 16'hFFFF)   r = RG_HRAM;
    else                                       r = RG_NONE;
    return r;
  endfunction

  function automatic port_e port_for(input region_e r, input logic split);
    port_e p;
    case (r)
      RG_CART: p = PT_CART;
      RG_WRAM: p = split ? PT_WRAM : PT_CART;
      default: p = PT_NONE;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sdma_engine.sv
module sdma_engine import sdma_pkg::*; #(
  parameter int COPY_LEN = 160,
  localparam int IW = $clog2(COPY_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [7:0]    page_i,
  input  logic          split_i,
  output logic          busy_o,
  output logic [IW-1:0] idx_o,
  output logic [7:0]    page_o,
  output logic          split_o,
  output logic [15:0]   src_addr_o,
  output port_e         src_port_o
);
  localparam logic [IW-1:0] LAST = IW'(COPY_LEN - 1);

  logic          busy_q, split_q;
  logic [IW-1:0] idx_q;
  logic [7:0]    page_q, page_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      page_q  <= 8'h00;
      split_q <= 1'b0;
    end else if (start_i && !busy_q) begin
      busy_q  <= 1'b1;
      idx_q   <= '0;
      page_q  <= page_i;
      split_q <= split_i;
    end else if (busy_q) begin
      if (idx_q == LAST) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  // pages at and above E0 mirror work RAM
  assign page_eff   = (page_q >= 8'hE0) ? (page_q & 8'hDF) : page_q;
  assign src_addr_o = {page_eff, 8'(idx_q)};
  assign src_port_o = port_for(region_of({page_eff, 8'h00}), split_q);
  assign busy_o     = busy_q;
  assign idx_o      = idx_q;
  assign page_o     = page_q;
  assign split_o    = split_q;

  p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> idx_q <= LAST);
  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_q) |=> (busy_q && idx_q == '0));
  p_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(idx_q) == LAST);
  p_page_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(page_q));

endmodule

// File: rtl/sdma_port_mux.sv
module sdma_port_mux import sdma_pkg::*; #(
  parameter port_e OWN_PORT = PT_CART
) (
  input  port_e       dma_port_i,
  input  logic [15:0] src_addr_i,
  input  logic        cpu_en_i,
  input  logic        cpu_we_i,
  input  port_e       cpu_port_i,
  input  logic [15:0] cpu_addr_i,
  input  logic [7:0]  cpu_wdata_i,
  output logic [15:0] addr_o,
  output logic        rd_o,
  output logic        wr_o,
  output logic [7:0]  wdata_o
);
  always_comb begin
    addr_o  = '0;
    rd_o    = 1'b0;
    wr_o    = 1'b0;
    wdata_o = '0;
    if (dma_port_i == OWN_PORT) begin
      addr_o = src_addr_i;
      rd_o   = 1'b1;
    end else if (cpu_en_i && cpu_port_i == OWN_PORT) begin
      addr_o  = cpu_addr_i;
      rd_o    = !cpu_we_i;
      wr_o    = cpu_we_i;
      wdata_o = cpu_wdata_i;
    end
  end
endmodule

// File: rtl/sdma_hram.sv
module sdma_hram #(
  parameter int DEPTH = 127,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i && addr_i < AW'(DEPTH)) mem[addr_i] <= wdata_i;
  end

  assign rdata_o = (addr_i < AW'(DEPTH)) ? mem[addr_i] : 8'hFF;
endmodule

// File: rtl/sprite_dma_hub.sv
module sprite_dma_hub import sdma_pkg::*; #(
  parameter int COPY_LEN   = 160,
  parameter int HRAM_DEPTH = 127
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        split_mode,
  input  logic        cpu_en,
  input  logic        cpu_we,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  output logic [7:0]  cpu_rdata,
  output logic        dma_busy,
  output logic [15:0] cart_addr,
  output logic        cart_rd,
  output logic        cart_wr,
  output logic [7:0]  cart_wdata,
  input  logic [7:0]  cart_rdata,
  output logic [15:0] wram_addr,
  output logic        wram_rd,
  output logic        wram_wr,
  output logic [7:0]  wram_wdata,
  input  logic [7:0]  wram_rdata,
  output logic [7:0]  oam_addr,
  output logic        oam_we,
  output logic [7:0]  oam_wdata,
  input  logic [7:0]  oam_rdata
);
  localparam int IW  = $clog2(COPY_LEN);
  localparam int HAW = $clog2(HRAM_DEPTH);

  region_e       cpu_rg;
  port_e         cpu_port, eng_port, dma_port;
  logic          busy, split_q, eff_split, start;
  logic [IW-1:0] idx;
  logic [7:0]    page_q, dma_byte, hram_rdata;
  logic [15:0]   src_addr;

  assign cpu_rg    = region_of(cpu_addr);
  assign eff_split = busy ? split_q : split_mode;
  assign cpu_port  = port_for(cpu_rg, eff_split);
  assign dma_port  = busy ? eng_port : PT_NONE;
  assign start     = cpu_en && cpu_we && (cpu_rg == RG_SRCREG) && !busy;

  sdma_engine #(.COPY_LEN(COPY_LEN)) eng_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .page_i     (cpu_wdata),
    .split_i    (split_mode),
    .busy_o     (busy),
    .idx_o      (idx),
    .page_o     (page_q),
    .split_o    (split_q),
    .src_addr_o (src_addr),
    .src_port_o (eng_port)
  );

  logic [15:0] bus_addr  [2];
  logic        bus_rd    [2];
  logic        bus_wr    [2];
  logic [7:0]  bus_wdata [2];

  for (genvar g = 0; g < 2; g++) begin : g_bus
    localparam port_e OWN = (g == 0) ? PT_CART : PT_WRAM;
    sdma_port_mux #(.OWN_PORT(OWN)) mux_i (
      .dma_port_i  (dma_port),
      .src_addr_i  (src_addr),
      .cpu_en_i    (cpu_en),
      .cpu_we_i    (cpu_we),
      .cpu_port_i  (cpu_port),
      .cpu_addr_i  (cpu_addr),
      .cpu_wdata_i (cpu_wdata),
      .addr_o      (bus_addr[g]),
      .rd_o        (bus_rd[g]),
      .wr_o        (bus_wr[g]),
      .wdata_o     (bus_wdata[g])
    );
  end

  assign cart_addr  = bus_addr[0];
  assign cart_rd    = bus_rd[0];
  assign cart_wr    = bus_wr[0];
  assign cart_wdata = bus_wdata[0];
  assign wram_addr  = bus_addr[1];
  assign wram_rd    = bus_rd[1];
  assign wram_wr    = bus_wr[1];
  assign wram_wdata = bus_wdata[1];

  always_comb begin
    case (eng_port)
      PT_CART: dma_byte = cart_rdata;
      PT_WRAM: dma_byte = wram_rdata;
      default: dma_byte = 8'hFF;
    endcase
  end

  // engine owns the sprite table for the whole copy
  assign oam_we    = busy | (cpu_en & cpu_we & (cpu_rg == RG_OAM));
  assign oam_addr  = busy ? 8'(idx) : cpu_addr[7:0];
  assign oam_wdata = busy ? dma_byte : cpu_wdata;

  sdma_hram #(.DEPTH(HRAM_DEPTH)) hram_i (
    .clk     (clk),
    .we_i    (cpu_en && cpu_we && (cpu_rg == RG_HRAM)),
    .addr_i  (cpu_addr[HAW-1:0]),
    .wdata_i (cpu_wdata),
    .rdata_o (hram_rdata)
  );

  always_comb begin
    case (cpu_rg)
      RG_CART, RG_WRAM: begin
        if (busy && cpu_port == dma_port) cpu_rdata = dma_byte;
        else if (cpu_port == PT_WRAM)     cpu_rdata = wram_rdata;
        else                              cpu_rdata = cart_rdata;
      end
      RG_OAM:    cpu_rdata = busy ? 8'hFF : oam_rdata;
      RG_HRAM:   cpu_rdata = hram_rdata;
      RG_SRCREG: cpu_rdata = page_q;
      default:   cpu_rdata = 8'hFF;
    endcase
  end

  assign dma_busy = busy;

  p_cart_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_port == PT_CART) |-> !cart_wr);
  p_wram_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_port == PT_WRAM) |-> !wram_wr);
  p_oam_owner_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (oam_we && oam_addr < COPY_LEN));
  p_rw_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(cart_rd && cart_wr) && !(wram_rd && wram_wr));

endmodule

// File: tb/sprite_dma_hub_tb_top.sv
`timescale 1ns/1ps
module sprite_dma_hub_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, split_mode, cpu_en, cpu_we;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata, cpu_rdata;
  logic        dma_busy;
  logic [15:0] cart_addr, wram_addr;
  logic        cart_rd, cart_wr, wram_rd, wram_wr, oam_we;
  logic [7:0]  cart_wdata, cart_rdata, wram_wdata, wram_rdata;
  logic [7:0]  oam_addr, oam_wdata, oam_rdata;

  sprite_dma_hub dut_i (.*);

  function automatic logic [7:0] cart_val(input logic [15:0] a);
    return a[7:0] * 8'd7 + a[15:8] + 8'h11;
  endfunction
  function automatic logic [7:0] wram_val(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], 1'b0} ^ 8'hC3;
  endfunction

  assign cart_rdata = cart_val(cart_addr);
  assign wram_rdata = wram_val(wram_addr);

  logic [7:0] oam_m [256];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) oam_m[i] <= 8'h00;
    end else if (oam_we) oam_m[oam_addr] <= oam_wdata;
  end
  assign oam_rdata = oam_m[oam_addr];

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit done = 0;
  bit xfer_on = 0;
  int start_cyc = 0;
  logic [7:0] page_cur = 0, reg_page = 0;
  bit split_cur = 0;
  logic [7:0] hram_m [127];

  // 0 cart, 1 wram, 2 sprite, 3 high ram, 4 source reg, 5 unmapped
  function automatic int reg_of(input logic [15:0] a);
    if (a < 16'h8000) return 0;
    if (a >= 16'hA000 && a < 16'hC000) return 0;
    if (a >= 16'hC000 && a < 16'hE000) return 1;
    if (a >= 16'hFE00 && a < 16'hFEA0) return 2;
    if (a == 16'hFF46) return 4;
    if (a >= 16'hFF80 && a < 16'hFFFF) return 3;
    return 5;
  endfunction
  // port: 0 none, 1 cart, 2 wram
  function automatic int port_b(input logic [15:0] a, input bit sp);
    int r = reg_of(a);
    if (r == 0) return 1;
    if (r == 1) return sp ? 2 : 1;
    return 0;
  endfunction
  function automatic logic [7:0] eff_page(input logic [7:0] p);
    return (p >= 8'hE0) ? p - 8'h20 : p;
  endfunction
  function automatic int dma_port_b(input logic [7:0] p, input bit sp);
    logic [7:0] e = eff_page(p);
    if (e >= 8'h80 && e < 8'hA0) return 0;
    if (e >= 8'hC0 && e < 8'hE0) return sp ? 2 : 1;
    return 1;
  endfunction
  function automatic logic [7:0] moving(input logic [7:0] p, input bit sp, input int k);
    logic [15:0] a = {eff_page(p), 8'(k)};
    int dp = dma_port_b(p, sp);
    if (dp == 0) return 8'hFF;
    if (dp == 1) return cart_val(a);
    return wram_val(a);
  endfunction
  function automatic bit special(input logic [7:0] p);
    return (p >= 8'hE0) || (p >= 8'h80 && p < 8'hA0);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit en, input bit we, input logic [15:0] a, input logic [7:0] d);
    int k, r, cp, dp;
    bit act, sp, exp_cw, exp_ww;
    logic [7:0] exp;
    string tag;
    @(negedge clk);
    cpu_en = en; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    #5;
    k = cyc - start_cyc;
    act = xfer_on && k >= 0 && k < 160;
    if (xfer_on && k >= 160) xfer_on = 0;
    chk(dma_busy == act, "R1", "busy", dma_busy, act);
    sp = act ? split_cur : split_mode;
    dp = act ? dma_port_b(page_cur, split_cur) : 0;
    cp = port_b(a, sp);
    r  = reg_of(a);
    if (act) begin
      tag = special(page_cur) ? "R10" : "R2";
      chk(oam_we && oam_addr == 8'(k) && oam_wdata == moving(page_cur, split_cur, k),
          tag, "sprite copy write", {oam_we, oam_addr, oam_wdata},
          {1'b1, 8'(k), moving(page_cur, split_cur, k)});
    end
    if (en && !we) begin
      case (r)
        0, 1: begin
          if (act && cp == dp) exp = moving(page_cur, split_cur, k);
          else exp = (cp == 2) ? wram_val(a) : cart_val(a);
          if (!act) tag = "R12";
          else if (dp == 0) tag = "R10";
          else if (!sp) tag = "R3";
          else tag = (dp == 2) ? "R4" : "R5";
        end
        2: begin exp = act ? 8'hFF : oam_m[a[7:0]]; tag = "R7"; end
        3: begin exp = hram_m[a - 16'hFF80]; tag = "R8"; end
        4: begin exp = reg_page; tag = act ? "R9" : "R1"; end
        default: begin exp = 8'hFF; tag = "R11"; end
      endcase
      chk(cpu_rdata == exp, tag, "cpu read", cpu_rdata, exp);
    end
    if (en && we) begin
      exp_cw = (cp == 1) && (dp != 1);
      exp_ww = (cp == 2) && (dp != 2);
      chk(cart_wr == exp_cw && (!exp_cw || (cart_addr == a && cart_wdata == d)),
          act ? "R6" : "R12", "cart write", {cart_wr, cart_addr}, {exp_cw, a});
      chk(wram_wr == exp_ww && (!exp_ww || (wram_addr == a && wram_wdata == d)),
          act ? "R6" : "R12", "wram write", {wram_wr, wram_addr}, {exp_ww, a});
      if (!act)
        chk(oam_we == (r == 2) && (r != 2 || (oam_addr == a[7:0] && oam_wdata == d)),
            "R7", "sprite cpu write", oam_we, (r == 2));
      if (r == 3) hram_m[a - 16'hFF80] = d;
      if (r == 4 && !act) begin
        reg_page = d; xfer_on = 1; start_cyc = cyc + 1;
        page_cur = d; split_cur = split_mode;
      end
    end
  endtask

  function automatic logic [15:0] rand_addr();
    case ($urandom % 8)
      0: return 16'($urandom % 32'h8000);
      1: return 16'hA000 + 16'($urandom % 32'h2000);
      2, 7: return 16'hC000 + 16'($urandom % 32'h2000);
      3: return 16'hFE00 + 16'($urandom % 160);
      4: return 16'hFF80 + 16'($urandom % 127);
      5: case ($urandom % 4)
           0: return 16'h8000 + 16'($urandom % 32'h2000);
           1: return 16'hE000 + 16'($urandom % 32'h1E00);
           2: return 16'hFEA0 + 16'($urandom % 96);
           default: return 16'hFFFF;
         endcase
      default: return 16'hFF46;
    endcase
  endfunction

  task automatic run_xfer(input logic [7:0] p, input bit sp, input bit poke);
    int bad = 0;
    logic [15:0] a;
    split_mode = sp;
    step(1, 1, 16'hFF46, p);
    for (int i = 0; i < 160; i++) begin
      if (poke && i == 5) step(1, 1, 16'hFF46, p ^ 8'h3C);
      else if (poke && i == 6) step(1, 0, 16'hFF46, 8'h00);
      else begin
        a = rand_addr();
        step(1, ($urandom % 4 == 0) && a != 16'hFF46, a, 8'($urandom));
      end
    end
    step(1, 0, 16'hFF46, 8'h00);
    chk(cpu_rdata == p, poke ? "R9" : "R1", "source reg after copy", cpu_rdata, p);
    for (int k = 0; k < 160; k++) if (oam_m[k] !== moving(p, sp, k)) bad++;
    chk(bad == 0, special(p) ? "R10" : "R2", "sprite table contents", bad, 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed_sink;
    seed_sink = $urandom(32'h5EED1234);
    rst_n = 0; split_mode = 0; cpu_en = 0; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #5;
    chk(dma_busy == 0 && oam_we == 0 && cart_rd == 0 && cart_wr == 0, "R1",
        "reset state", {dma_busy, oam_we, cart_rd, cart_wr}, 0);
    step(1, 0, 16'hFF46, 0);
    // fill high RAM
    for (int i = 0; i < 127; i++) step(1, 1, 16'hFF80 + 16'(i), 8'(i * 5 + 3));
    step(1, 0, 16'hFF80, 0);
    step(1, 0, 16'hFFFE, 0);
    // idle routing
    split_mode = 0;
    step(1, 0, 16'h1234, 0);
    step(1, 0, 16'hC123, 0);
    step(1, 1, 16'hC200, 8'h77);
    split_mode = 1;
    step(1, 0, 16'hC123, 0);
    step(1, 0, 16'hB00F, 0);
    step(1, 1, 16'hA010, 8'h5C);
    step(1, 1, 16'hC200, 8'h66);
    // unmapped
    step(1, 0, 16'h8100, 0);
    step(1, 0, 16'hE100, 0);
    step(1, 0, 16'hFEB0, 0);
    step(1, 0, 16'hFF10, 0);
    step(1, 0, 16'hFFFF, 0);
    // sprite table idle access
    step(1, 1, 16'hFE05, 8'hA7);
    step(1, 0, 16'hFE05, 0);
    // directed copies
    run_xfer(8'hC1, 0, 0);
    run_xfer(8'hC3, 1, 0);
    run_xfer(8'h40, 1, 0);
    run_xfer(8'h12, 0, 0);
    run_xfer(8'hE5, 1, 0);
    run_xfer(8'h88, 1, 0);
    run_xfer(8'hA2, 1, 1);
    run_xfer(8'h00, 0, 0);
    for (int n = 0; n < 5; n++) begin
      logic [7:0] p;
      case ($urandom % 4)
        0: p = 8'($urandom % 128);
        1: p = 8'hA0 + 8'($urandom % 32);
        2: p = 8'hC0 + 8'($urandom % 32);
        default: p = 8'hE0 + 8'($urandom % 32);
      endcase
      run_xfer(p, 1'($urandom % 2), 0);
    end
    step(0, 0, 16'h0000, 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule